// File: doc/BRIEF.md
# Write bus cycle generator

This block turns a single write request into one complete write transfer on a bus that carries address and data on the same lines. It shows the address with a one-clock latch-enable pulse, then switches the shared lines over to the write data, holds an active-low write strobe low while a slave may stretch the transfer through a ready input, and returns the strobe high one clock before the drive and the active-low chip select let go. A one-clock done pulse marks the final clock of each transfer.

All timing is counted in whole clocks and is tied to the clock in which the write strobe rises. A transfer with no wait states takes four clocks. Every clock in which ready is low at the sampling point adds one clock to the strobe and to the transfer. The gap after the strobe rises is never stretched: when a request is waiting, the next strobe falls exactly three clocks after the previous one rose. A request is taken only while the block is idle. Requests raised during a transfer are not queued and do not disturb the transfer in progress. The reset input is asynchronous and active low, and the block leaves reset only on a clock edge.

Top module: `wbus_write_gen`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, cs_n and wr_n are 1 and ale, ad_oe and done are 0. No request is taken during that time.
- R2: A request present while the block is idle starts a transfer on the next clock. A request raised or changed at any other time is ignored: the address and data already taken stay on ad_out.
- R3: In the first clock of a transfer, ale is 1 for exactly that one clock, ad_out carries the address, ad_oe is 1, cs_n is 0 and wr_n is 1.
- R4: From the second clock through the last clock of the transfer, ad_out carries the write data, zero-extended to the bus width. wr_n is 0 from the second clock until the strobe rises.
- R5: A transfer with no wait states keeps cs_n low for 4 clocks and wr_n low for 2 clocks.
- R6: ready is sampled once per clock from the third clock on. Each sample of 0 adds one clock to the cs_n low time and to the wr_n low time.
- R7: ready has no effect in the address clock, the first strobe clock, the final clock or while idle.
- R8: When a request waits for the next transfer, wr_n stays high for exactly 3 clocks between strobes, whatever the wait count of the previous transfer.
- R9: In the final clock, wr_n is 1 while ad_oe is still 1 and ad_out still carries the data. ad_oe is 0 in the clock after that.
- R10: done is 1 for exactly one clock: the final clock of a transfer, which is the clock in which wr_n rises.
- R11: cs_n returns to 1 in the clock after the final clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| wr_req | input | 1 | Write request; taken only while idle |
| wr_addr | input | ADDR_W | Address of the requested write |
| wr_data | input | DATA_W | Data of the requested write |
| ready | input | 1 | Slave ready; 0 at a sampling clock adds one wait clock |
| ale | output | 1 | Address latch enable, high in the address clock |
| ad_out | output | max(ADDR_W, DATA_W) | Value driven on the shared address/data lines |
| ad_oe | output | 1 | Output enable for ad_out |
| cs_n | output | 1 | Active-low chip select |
| wr_n | output | 1 | Active-low write strobe |
| done | output | 1 | One-clock pulse in the final clock of a transfer |

## Verification
The bench builds the block with ADDR_W = 20 and DATA_W = 16. The shared lines are therefore wider than the data, and the four upper lines must carry address bits in the address clock and zeros in the data clocks. Ready patterns hold the strobe for anywhere from 0 to 15 wait clocks, and back-to-back requests with mixed wait counts put the fixed three-clock gap under test. Requests and ready are also toggled in the clocks where they must be ignored.

// File: rtl/wbus_pkg.sv
package wbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_STROBE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_HOLD   = 3'd4
  } wb_state_e;

  typedef struct packed {
    logic ale;
    logic cs_n;
    logic wr_n;
    logic oe;
    logic done;
    logic sel_data;
  } wb_ctl_t;

  localparam wb_ctl_t CTL_IDLE = '{ale: 1'b0, cs_n: 1'b1, wr_n: 1'b1,
                                   oe: 1'b0, done: 1'b0, sel_data: 1'b0};

  // Pin levels for the clock spent in a given state
  function automatic wb_ctl_t ctl_for(wb_state_e st);
    wb_ctl_t c;
    c = CTL_IDLE;
    case (st)
      ST_ADDR: begin
        c.ale  = 1'b1;
        c.cs_n = 1'b0;
        c.oe   = 1'b1;
      end
      ST_STROBE, ST_SAMPLE: begin
        c.cs_n     = 1'b0;
        c.wr_n     = 1'b0;
        c.oe       = 1'b1;
        c.sel_data = 1'b1;
      end
      ST_HOLD: begin
        c.cs_n     = 1'b0;
        c.oe       = 1'b1;
        c.done     = 1'b1;
        c.sel_data = 1'b1;
      end
      default: c = CTL_IDLE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/wbus_rst_sync.sv
module wbus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/wbus_fsm.sv
module wbus_fsm
  import wbus_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_req,
  input  logic      ready,
  output wb_state_e state_d,
  output logic      accept
);

  wb_state_e state_q;

  always_comb begin
    accept  = 1'b0;
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (wr_req) begin
          accept  = 1'b1;
          state_d = ST_ADDR;
        end
      end
      ST_ADDR:   state_d = ST_STROBE;
      ST_STROBE: state_d = ST_SAMPLE;
      ST_SAMPLE: state_d = ready ? ST_HOLD : ST_SAMPLE;
      ST_HOLD:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/wbus_drive.sv
module wbus_drive
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  wb_state_e         state_d,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ale,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic              cs_n,
  output logic              wr_n,
  output logic              done
);

  wb_ctl_t           ctl_q;
  wb_ctl_t           ctl_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BUS_W-1:0]  addr_ext;
  logic [BUS_W-1:0]  data_ext;

  always_comb begin
    ctl_d = ctl_for(state_d);
  end

  // Every pin leaves a flop of its own so no strobe can glitch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_IDLE;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  // Request capture, enabled only when a request is taken
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (accept) begin
      addr_q <= wr_addr;
      data_q <= wr_data;
    end
  end

  generate
    if (ADDR_W < BUS_W) begin : g_addr_pad
      assign addr_ext = {{(BUS_W-ADDR_W){1'b0}}, addr_q};
    end else begin : g_addr_full
      assign addr_ext = addr_q;
    end
    if (DATA_W < BUS_W) begin : g_data_pad
      assign data_ext = {{(BUS_W-DATA_W){1'b0}}, data_q};
    end else begin : g_data_full
      assign data_ext = data_q;
    end
  endgenerate

  assign ad_out = ctl_q.sel_data ? data_ext : addr_ext;
  assign ale    = ctl_q.ale;
  assign ad_oe  = ctl_q.oe;
  assign cs_n   = ctl_q.cs_n;
  assign wr_n   = ctl_q.wr_n;
  assign done   = ctl_q.done;

endmodule

// File: rtl/wbus_write_gen.sv
module wbus_write_gen
  import wbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ready,
  output logic              ale,
  output logic [BUS_W-1:0]  ad_out,
  output logic              ad_oe,
  output logic              cs_n,
  output logic              wr_n,
  output logic              done
);

  logic      srst_n;
  logic      accept;
  wb_state_e state_d;

  wbus_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wbus_fsm u_fsm (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_req  (wr_req),
    .ready   (ready),
    .state_d (state_d),
    .accept  (accept)
  );

  wbus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk     (clk),
    .rst_n   (srst_n),
    .accept  (accept),
    .state_d (state_d),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ale     (ale),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .done    (done)
  );

endmodule

// File: rtl/wbus_write_chk.sv
module wbus_write_chk #(
  parameter int BUS_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ale,
  input logic [BUS_W-1:0] ad_out,
  input logic             ad_oe,
  input logic             cs_n,
  input logic             wr_n,
  input logic             done
);

  // R3: the address clock drives the lines with chip select on and strobe off
  a_r3_addr_phase: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!cs_n && wr_n && ad_oe));

  // R3, R4: latch enable lasts one clock and the strobe falls right after it
  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && !wr_n));

  // R4: chip select and the drive cover the whole strobe
  a_r4_strobe_covered: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_n && ad_oe && !ale));

  // R4: the lines keep their value while the strobe stays low
  a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(ad_out));

  // R8: the gap after the strobe rises is fixed
  a_r8_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |=> wr_n ##1 wr_n);

  // R10: done marks the clock in which the strobe rises, and only that clock
  a_r10_done_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> done);
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_origin: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(!wr_n) && wr_n && ad_oe));

  // R9: the drive is released one clock after the strobe went high
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ad_oe) |-> ($past(wr_n) && $past(done)));

  // R11: chip select is released right after the final clock
  a_r11_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(done) && !ad_oe));

endmodule

bind wbus_write_gen wbus_write_chk #(.BUS_W(BUS_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ale    (ale),
  .ad_out (ad_out),
  .ad_oe  (ad_oe),
  .cs_n   (cs_n),
  .wr_n   (wr_n),
  .done   (done)
);

// File: tb/tb_wbus_write_gen.sv
module tb_wbus_write_gen;

  localparam int AW = 20;
  localparam int DW = 16;
  localparam int BW = (AW > DW) ? AW : DW;

  logic          clk;
  logic          rst_n;
  logic          wr_req;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          ready;
  logic          ale;
  logic [BW-1:0] ad_out;
  logic          ad_oe;
  logic          cs_n;
  logic          wr_n;
  logic          done;

  int n_tests;
  int n_fail;
  int cyc;
  int rise_cyc;
  bit finished;

  wbus_write_gen #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ready   (ready),
    .ale     (ale),
    .ad_out  (ad_out),
    .ad_oe   (ad_oe),
    .cs_n    (cs_n),
    .wr_n    (wr_n),
    .done    (done)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic chk_pins(input string req, input logic e_ale, input logic e_cs,
                          input logic e_wr, input logic e_oe, input logic e_done);
    chk(req, "ale",   32'(ale),   32'(e_ale));
    chk(req, "cs_n",  32'(cs_n),  32'(e_cs));
    chk(req, "wr_n",  32'(wr_n),  32'(e_wr));
    chk(req, "ad_oe", 32'(ad_oe), 32'(e_oe));
    chk(req, "done",  32'(done),  32'(e_done));
  endtask

  // Number of wait clocks: index of the first ready sample that is 1
  function automatic int waits_of(input logic [15:0] rmask);
    for (int j = 0; j < 16; j++) begin
      if (rmask[j]) return j;
    end
    return 15;
  endfunction

  function automatic logic [31:0] data_bus(input logic [DW-1:0] d);
    return 32'(d);
  endfunction

  // Called at a falling edge with the block idle; ends one clock after the final clock
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [15:0] rmask_in, input bit chained);
    logic [15:0] rmask;
    int          nw;
    int          t1_cyc;
    int          t2_cyc;
    rmask = rmask_in | 16'h8000;
    nw    = waits_of(rmask);
    wr_req  = 1'b1;
    wr_addr = a;
    wr_data = d;
    ready   = 1'($urandom);               // R7: ignored while idle
    @(negedge clk);                       // address clock
    t1_cyc = cyc;
    chk_pins("R3", 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
    chk("R3", "ad_out address", 32'(ad_out), 32'(a));
    wr_req  = 1'b1;                       // R2: request while busy
    wr_addr = ~a;
    wr_data = ~d;
    ready   = 1'($urandom);               // R7: ignored in address clock
    @(negedge clk);                       // first strobe clock
    t2_cyc = cyc;
    chk_pins("R4", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R4", "ad_out data", 32'(ad_out), data_bus(d));
    if (chained) chk("R8", "high clocks between strobes", 32'(t2_cyc - rise_cyc), 32'd3);
    ready = 1'($urandom);                 // R7: ignored in first strobe clock
    for (int j = 0; j < 16; j++) begin
      @(negedge clk);                     // sampling clock
      chk_pins("R6", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
      chk("R2", "ad_out data kept", 32'(ad_out), data_bus(d));
      ready = rmask[j];
      if (rmask[j]) break;
    end
    @(negedge clk);                       // final clock
    rise_cyc = cyc;
    chk_pins("R10", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R9", "ad_out data hold", 32'(ad_out), data_bus(d));
    chk(nw == 0 ? "R5" : "R6", "wr_n low clocks", 32'(rise_cyc - t2_cyc), 32'(2 + nw));
    ready   = 1'($urandom);               // R7: ignored in final clock
    wr_req  = 1'b1;                       // R2: not taken until idle
    wr_addr = ~a;
    wr_data = ~d;
    @(negedge clk);                       // idle again
    chk_pins("R11", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    chk(nw == 0 ? "R5" : "R6", "cs_n low clocks", 32'(cyc - t1_cyc), 32'(4 + nw));
    wr_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    n_tests  = 0;
    n_fail   = 0;
    cyc      = 0;
    rise_cyc = -100;
    finished = 1'b0;
    rst_n    = 1'b0;
    wr_req   = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    ready    = 1'b0;

    repeat (3) @(negedge clk);
    chk_pins("R1", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    rst_n  = 1'b1;
    wr_req = 1'b1;                        // R1: not taken while release is pending
    @(negedge clk);
    chk_pins("R1", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    wr_req = 1'b0;
    @(negedge clk);
    chk_pins("R1", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    chk_pins("R1", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

    // Directed corner cases
    do_write(20'h12345, 16'hA5C3, 16'h0001, 1'b0);   // R5 no wait state
    do_write(20'hFFFFF, 16'hFFFF, 16'h8000, 1'b1);   // R6 longest stretch, R8 after it
    do_write(20'h00000, 16'h0000, 16'h0001, 1'b1);   // R8 after 15 waits
    do_write(20'hF0F0F, 16'h0F0F, 16'h0004, 1'b1);
    repeat (3) @(negedge clk);
    chk_pins("R2", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);

    // Random writes with random gaps and ready patterns
    for (int i = 0; i < 60; i++) begin
      int gap;
      logic [15:0] rm;
      gap = int'($urandom_range(0, 2));
      rm  = 16'($urandom) & 16'($urandom);
      repeat (gap) begin
        ready = 1'($urandom);
        @(negedge clk);
        chk_pins("R7", 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      end
      do_write(AW'($urandom), DW'($urandom), rm, gap == 0);
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule